// File: doc/BRIEF.md
# Watchdog Basic Timer with Oscillator Stabilization

This block pairs a selectable clock prescaler with a read-only up counter and uses that single counter for two jobs. In normal running it is a watchdog: software must clear the counter regularly, and if the counter ever wraps past its top value a one-cycle system reset pulse is produced. A 4-bit key in the upper control bits turns that reset off.

The same counter also times oscillator stabilization. After power-on reset, or when an interrupt wakes the system out of stop mode, the counter restarts from zero. The CPU is held idle until counter bit 4 becomes set. After power-on the count always runs at the slowest prescaler rate. After a wake it runs at the rate held in the control register.

The watchdog pulse reinitializes the whole block in the same way as power-on reset. The block therefore re-enters its power-on stabilization wait on its own.

Top module: `bt_watchdog_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `ctrl_rdata` is 0x00, `cnt_rdata` is 0, `wdt_rst` and `cpu_run` are 0, and `clk_gate_en` is 1.
- R2: After power-on reset the counter advances once every DIV_LONG cycles, whatever is written to control bits [3:2] meanwhile. `cpu_run` rises together with counter bit 4, exactly 16*DIV_LONG clock edges after the last edge with `rst_n` low.
- R3: A `wake_irq` accepted in stop mode zeroes the prescaler and the counter. Counting then runs at the rate given by control bits [3:2]: 00 = DIV_LONG, 01 = DIV_MID, 10 = DIV_SHORT, and 11 acts like 10. `cpu_run` rises 16*DIV edges after the accepting edge, at the moment counter bit 4 becomes set.
- R4: A `stop_req` sampled while `cpu_run` is high enters stop mode. There `cpu_run` and `clk_gate_en` are 0 and the counter holds its value. A `stop_req` outside run mode and a `wake_irq` outside stop mode have no effect.
- R5: `ctrl_rdata` returns control bits [7:2] as last written, with bits [1:0] reading 0.
- R6: A write with bit 1 set clears the counter on that edge, and bit 1 wins over a coincident tick. A write with bit 0 set restarts the prescaler. A write with bit 1 clear leaves the counter value unchanged.
- R7: When control bits [7:4] differ from 1010b and the counter wraps from 255 to 0, `wdt_rst` is high for exactly one cycle, starting at the edge after the wrap.
- R8: While control bits [7:4] equal 1010b, a counter wrap produces no `wdt_rst`.
- R9: On the edge after `wdt_rst` the control register, counter and prescaler return to their reset values, `cpu_run` goes low, and a new power-on stabilization wait (R2) begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator output) |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control write data: [7:4] key, [3:2] rate, [1] clear counter, [0] clear prescaler |
| ctrl_rdata | output | 8 | Control register read value |
| cnt_rdata | output | 8 | Counter read value |
| stop_req | input | 1 | Request to enter stop mode |
| wake_irq | input | 1 | External interrupt wakeup from stop mode |
| wdt_rst | output | 1 | One-cycle watchdog system reset pulse |
| cpu_run | output | 1 | CPU may execute |
| clk_gate_en | output | 1 | Oscillator-derived clock enable, low in stop mode |

## Verification
The bench builds the block with DIV_LONG=16, DIV_MID=8 and DIV_SHORT=4, keeping the 8-bit counter and the bit-4 stabilization point. With these values a full wrap at the fastest rate takes 1024 cycles and the power-on wait takes 256. Every overflow, every re-entry into stabilization after a watchdog reset, and the wait at each rate can be measured exactly to the edge, within a short run. Because the three ratios are distinct, a swapped rate select would show up as a wrong wait length.

// File: rtl/bt_pkg.sv
// Package: shared types and constants for the watchdog basic timer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bt_pkg;
    typedef enum logic [1:0] {
        MODE_STAB = 2'd0,   // stabilization wait, CPU idle
        MODE_RUN  = 2'd1,   // normal operation
        MODE_STOP = 2'd2    // oscillator stopped, everything frozen
    } bt_mode_e;

    localparam logic [3:0] WDT_OFF_KEY = 4'b1010;
endpackage

// File: rtl/bt_prescaler.sv
// Module: bt_prescaler
// Divides the input clock by one of three ratios and emits a one-cycle tick.
// Assumes: DIV_LONG is the largest ratio and every ratio is at least 2.
module bt_prescaler #(
    parameter int DIV_LONG  = 4096,
    parameter int DIV_MID   = 1024,
    parameter int DIV_SHORT = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       use_long,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PW = $clog2(DIV_LONG);

    logic [PW-1:0] pre;
    logic [PW-1:0] limit;

    // Pick the terminal count; the long ratio is forced during power-on wait.
    always_comb begin
        if (use_long) begin
            limit = PW'(DIV_LONG - 1);
        end else begin
            case (sel)
                2'b00:   limit = PW'(DIV_LONG - 1);
                2'b01:   limit = PW'(DIV_MID - 1);
                default: limit = PW'(DIV_SHORT - 1);
            endcase
        end
    end

    assign tick = en && !clr && (pre >= limit);

    // Divider count: restart on clear or on tick, hold when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clr) begin
            pre <= '0;
        end else if (en) begin
            pre <= tick ? '0 : pre + 1'b1;
        end
    end
endmodule

// File: rtl/bt_counter.sv
// Module: bt_counter
// Up counter advanced by prescaler ticks; reports each increment and each wrap.
// Assumes: clr has priority over tick.
module bt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             inc,
    output logic             wrap
);
    assign inc  = tick && !clr;
    assign wrap = inc && (&cnt);

    // Counter value: clear, else increment on tick (natural wrap).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bt_sequencer.sv
// Module: bt_sequencer
// Tracks run, stop and stabilization modes and which rate the wait uses.
// Assumes: stab_hit is a single-cycle pulse when the counter reaches the stable point.
module bt_sequencer
    import bt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stop_req,
    input  logic     wake_irq,
    input  logic     stab_hit,
    output bt_mode_e mode,
    output logic     por_wait,
    output logic     wake_clr
);
    assign wake_clr = (mode == MODE_STOP) && wake_irq;

    // Mode transitions; reset enters a power-on stabilization wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_STAB;
            por_wait <= 1'b1;
        end else begin
            case (mode)
                MODE_RUN: begin
                    if (stop_req) mode <= MODE_STOP;
                end
                MODE_STOP: begin
                    if (wake_irq) begin
                        mode     <= MODE_STAB;
                        por_wait <= 1'b0;
                    end
                end
                default: begin
                    if (stab_hit) mode <= MODE_RUN;
                end
            endcase
        end
    end
endmodule

// File: rtl/bt_watchdog_timer.sv
// Module: bt_watchdog_timer (top)
// Watchdog and oscillator stabilization timer sharing one prescaled counter.
// Assumes: rst_n is synchronous power-on reset; wdt_rst is fed back internally
// so the block reinitializes itself on a watchdog expiry.
module bt_watchdog_timer
    import bt_pkg::*;
#(
    parameter int DIV_LONG  = 4096,
    parameter int DIV_MID   = 1024,
    parameter int DIV_SHORT = 128,
    parameter int CNT_W     = 8,
    parameter int STAB_BIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       ctrl_rdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             stop_req,
    input  logic             wake_irq,
    output logic             wdt_rst,
    output logic             cpu_run,
    output logic             clk_gate_en
);
    localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'((1 << STAB_BIT) - 1);

    logic       init_n;
    logic [5:0] ctrl_q;
    logic       tick;
    logic       inc;
    logic       wrap;
    logic       por_wait;
    logic       wake_clr;
    logic       stab_hit;
    logic       cnt_clr;
    logic       pre_clr;
    bt_mode_e   mode;

    assign init_n  = rst_n && !wdt_rst;
    assign cnt_clr = wake_clr || (wr_en && wr_data[1]);
    assign pre_clr = wake_clr || (wr_en && wr_data[0]);

    // Control register: key and rate bits; clear bits are not stored.
    always_ff @(posedge clk) begin
        if (!init_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data[7:2];
        end
    end

    bt_prescaler #(
        .DIV_LONG (DIV_LONG),
        .DIV_MID  (DIV_MID),
        .DIV_SHORT(DIV_SHORT)
    ) u_pre (
        .clk     (clk),
        .rst_n   (init_n),
        .clr     (pre_clr),
        .en      (mode != MODE_STOP),
        .use_long(por_wait && (mode == MODE_STAB)),
        .sel     (ctrl_q[1:0]),
        .tick    (tick)
    );

    bt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(init_n),
        .clr  (cnt_clr),
        .tick (tick),
        .cnt  (cnt_rdata),
        .inc  (inc),
        .wrap (wrap)
    );

    assign stab_hit = (mode == MODE_STAB) && inc && (cnt_rdata == STAB_LAST);

    bt_sequencer u_seq (
        .clk     (clk),
        .rst_n   (init_n),
        .stop_req(stop_req),
        .wake_irq(wake_irq),
        .stab_hit(stab_hit),
        .mode    (mode),
        .por_wait(por_wait),
        .wake_clr(wake_clr)
    );

    // Watchdog pulse: one cycle after an armed wrap, dropped by its own reinit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst <= 1'b0;
        end else if (wdt_rst) begin
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= wrap && (ctrl_q[5:2] != WDT_OFF_KEY);
        end
    end

    assign ctrl_rdata  = {ctrl_q, 2'b00};
    assign cpu_run     = (mode == MODE_RUN);
    assign clk_gate_en = (mode != MODE_STOP);
endmodule

// File: rtl/bt_watchdog_timer_chk.sv
// Module: bt_watchdog_timer_chk
// Port-level temporal checks for bt_watchdog_timer, attached by bind.
// Assumes: synchronous active-low rst_n; checks are off while it is low.
module bt_watchdog_timer_chk #(
    parameter int CNT_W    = 8,
    parameter int STAB_BIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_any,
    input logic             wr_clr,
    input logic             wake_irq,
    input logic [7:0]       ctrl_rdata,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic             wdt_rst,
    input logic             cpu_run,
    input logic             clk_gate_en
);
    localparam logic [CNT_W-1:0] STAB_VAL = CNT_W'(1 << STAB_BIT);

    // R7: the watchdog pulse lasts one cycle
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    // R9: the pulse reinitializes control, counter and run state
    assert_reinit_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (ctrl_rdata == 8'h00 && cnt_rdata == '0 && !cpu_run));

    // R8: the disable key suppresses the pulse
    assert_key_blocks_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7:4] == 4'b1010) |=> !wdt_rst);

    // R4: stop mode holds the CPU and freezes the counter
    assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_gate_en |-> !cpu_run);
    assert_stop_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_gate_en && !wake_irq && !wr_any) |=> $stable(cnt_rdata));

    // R6: a clear write zeroes the counter
    assert_clear_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (cnt_rdata == '0));

    // R2 and R3: the CPU starts exactly when counter bit 4 becomes set
    assert_run_at_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> (cnt_rdata == STAB_VAL));

    // R5: clear bits always read as zero
    always_comb begin
        if (rst_n) begin
            assert_clear_bits_read_zero_R5: assert (ctrl_rdata[1:0] == 2'b00);
        end
    end
endmodule

bind bt_watchdog_timer bt_watchdog_timer_chk #(
    .CNT_W   (CNT_W),
    .STAB_BIT(STAB_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_any     (wr_en),
    .wr_clr     (wr_en && wr_data[1]),
    .wake_irq   (wake_irq),
    .ctrl_rdata (ctrl_rdata),
    .cnt_rdata  (cnt_rdata),
    .wdt_rst    (wdt_rst),
    .cpu_run    (cpu_run),
    .clk_gate_en(clk_gate_en)
);

// File: tb/bt_watchdog_timer_bench.sv
`timescale 1ns/1ps
module bt_watchdog_timer_bench;
    localparam int DL = 16;
    localparam int DM = 8;
    localparam int DS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic [7:0] ctrl_rdata;
    logic [7:0] cnt_rdata;
    logic       wdt_rst;
    logic       cpu_run;
    logic       clk_gate_en;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bt_watchdog_timer #(
        .DIV_LONG(DL), .DIV_MID(DM), .DIV_SHORT(DS), .CNT_W(8), .STAB_BIT(4)
    ) u_bt_watchdog_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_rdata(ctrl_rdata), .cnt_rdata(cnt_rdata), .stop_req(stop_req),
        .wake_irq(wake_irq), .wdt_rst(wdt_rst), .cpu_run(cpu_run),
        .clk_gate_en(clk_gate_en)
    );

    always @(posedge clk) if (rst_n && wdt_rst) pulses++;

    // control value written before a stop/wake, expected wait in edges
    localparam int NV = 4;
    localparam logic [7:0] VEC_CTRL [NV] = '{8'hA0, 8'hA4, 8'hA8, 8'h04};
    localparam int         VEC_WAIT [NV] = '{16*DL, 16*DM, 16*DS, 16*DM};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    // edges after the current one until cpu_run goes high
    task automatic wait_run(output int n);
        n = 0;
        while (!cpu_run && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int cnt0;
        int p0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ctrl", ctrl_rdata, 0);
        check("R1 cnt", cnt_rdata, 0);
        check("R1 run/wdt", {cpu_run, wdt_rst}, 0);
        check("R1 gate", clk_gate_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle out", {cpu_run, wdt_rst, clk_gate_en}, 1);
        // R2: rate bits written during power-on wait are ignored; stop ignored in wait
        write_ctrl(8'hA8);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R4 stop ignored in wait", clk_gate_en, 1);
        n = 3;
        while (!cpu_run && n < 5000) begin @(negedge clk); n++; end
        check("R2 power-on wait", n, 16*DL);
        check("R2 count at start", cnt_rdata, 16);

        // R3: table of wake rates
        for (int i = 0; i < NV; i++) begin
            write_ctrl(VEC_CTRL[i] | 8'h03);
            check("R5 readback", ctrl_rdata, VEC_CTRL[i]);
            stop_req = 1'b1;
            @(negedge clk);
            stop_req = 1'b0;
            check("R4 stop entered", {clk_gate_en, cpu_run}, 0);
            wake_irq = 1'b1;
            @(negedge clk);
            wake_irq = 1'b0;
            check("R3 counter zeroed on wake", cnt_rdata, 0);
            wait_run(n);
            check("R3 wake wait", n, VEC_WAIT[i]);
        end

        // R4: frozen in stop, wake ignored while running
        repeat (30) @(negedge clk);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        check("R4 wake ignored in run", cpu_run, 1);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        cnt0 = cnt_rdata;
        repeat (100) @(negedge clk);
        check("R4 frozen count", cnt_rdata, cnt0);
        check("R4 run low in stop", cpu_run, 0);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        wait_run(n);

        // R6: write without clear keeps the counter, with clear zeroes it
        repeat (40) @(negedge clk);
        cnt0 = cnt_rdata;
        write_ctrl(8'hA8);
        check("R6 no clear keeps count", (cnt_rdata >= cnt0) ? 1 : 0, 1);
        check("R6 no clear keeps count nonzero", (cnt_rdata != 0) ? 1 : 0, 1);
        write_ctrl(8'hAA);
        check("R6 clear bit", cnt_rdata, 0);

        // R8: disable key, counter wraps without reset
        write_ctrl(8'hAB);
        p0 = pulses;
        repeat (256*DS + 100) @(negedge clk);
        check("R8 no pulse with key", pulses - p0, 0);
        check("R8 still running", cpu_run, 1);

        // R7: armed watchdog expires 256 ticks after clearing counter and prescaler
        write_ctrl(8'h0B);
        n = 0;
        while (!wdt_rst && n < 5000) begin @(negedge clk); n++; end
        check("R7 overflow time", n, 256*DS);
        @(negedge clk);
        check("R7 single pulse", wdt_rst, 0);
        check("R9 ctrl reinit", ctrl_rdata, 0);
        check("R9 cnt/run reinit", {cnt_rdata, cpu_run}, 0);
        n = 0;
        while (!cpu_run && n < 5000) begin @(negedge clk); n++; end
        check("R9 new power-on wait", n, 16*DL);
        check("R7 pulse count", pulses - p0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule